// File: doc/BRIEF.md
# Restrainable Error Status and Trap Request Controller

This block records restrainable memory errors (uncorrectable, correctable and degraded) that an external checker reports. Each report sets a sticky pending bit in a status register. A software-programmed enable register holds two trap enables. One covers the uncorrectable class. The other is shared by the correctable and degraded classes. When a pending error meets its enable, the block raises an error-trap request to the core's trap logic. The request stays up until that logic acknowledges it.

Software reaches both registers through a simple word-wide register port. Reads are combinational. A write takes effect at the next clock edge. Pending bits are cleared by writing ones to them.

The request is latched, so a deliberate race exists. If software clears a pending bit after the request has armed but before it is acknowledged, the trap is still delivered even though the status no longer shows a matching error. A small cause field, captured when the request arms, records which enabled class fired it. Trap handlers are expected to tolerate such an empty-status trap.

Top module: `rerr_ctrl`

## Requirements
- R1: After a synchronous active-low reset, the status register reads 0, the enable register reads 0, `trap_req` is 0 and `trap_cause` is 0.
- R2: A pulse on `det_ue`, `det_ce` or `det_dg` sets status bit 0, 1 or 2 respectively (status register at address 0) from the next clock edge. The bit then stays set with no further pulses.
- R3: A write to address 0 clears each status bit whose write-data bit is 1. Status bits written with 0 keep their value.
- R4: If a detection and a write-1 clear hit the same status bit in the same cycle, the bit is set after the edge.
- R5: The enable register is at address 1. Bit 0 enables the uncorrectable class and bit 1 enables the correctable/degraded class. A write stores data bits [1:0], and reads return them with all other bits 0.
- R6: `trap_req` rises at the clock edge after the cycle in which (status bit 0 AND enable bit 0) OR ((status bit 1 OR status bit 2) AND enable bit 1) is true, provided `trap_ack` is low. It never rises while that condition is false, so pending errors with their enable at 0 raise no request.
- R7: Once high, `trap_req` stays high until a cycle with `trap_ack` high, even if software clears the matching status bits or enables. It is low after that acknowledge edge.
- R8: If the trap condition still holds after an acknowledge, `trap_req` is low for exactly one cycle and then rises again.
- R9: When `trap_req` rises, `trap_cause` captures which enabled classes fired it: bit 0 for uncorrectable, bit 1 for correctable/degraded. It holds that value until the acknowledge and is 0 after it.
- R10: Reads of any address other than 0 or 1 return 0, and writes to such addresses change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| det_ue | input | 1 | Uncorrectable error detected (one-cycle pulse) |
| det_ce | input | 1 | Correctable error detected |
| det_dg | input | 1 | Degraded error detected |
| reg_addr | input | AW (4) | Register word address |
| reg_wen | input | 1 | Register write strobe |
| reg_wdata | input | DW (32) | Register write data |
| reg_rdata | output | DW (32) | Register read data for `reg_addr` (combinational) |
| trap_ack | input | 1 | Trap logic accepted the request |
| trap_req | output | 1 | Error-trap request, held until acknowledged |
| trap_cause | output | 2 | Classes that armed the current request |

## Verification
The bench targets the race. It clears a status bit while a request is outstanding and expects the request to survive with an empty status read. A design that gates the request combinationally with the live status would drop it. It also checks detection colliding with a write-1 clear, where a design with clear priority would lose the error, and writes of zero, which a plain-store register would turn into clears. It checks acknowledge with a still-true condition: re-arming at once or never re-arming each shows up as a wrong `trap_req` cycle. It checks cross-class clears after a trap, where a live cause field would change while the request is held.

// File: rtl/rerr_pkg.sv
// Shared constants and types for the restrainable error controller.
// Assumes three error classes and two trap enables; bit positions are
// software-visible and must not be reordered.
package rerr_pkg;
    localparam int NCLS   = 3;   // pending classes
    localparam int NEN    = 2;   // trap enable groups
    localparam int IDX_UE = 0;
    localparam int IDX_CE = 1;
    localparam int IDX_DG = 2;
    localparam int GRP_UE = 0;
    localparam int GRP_CD = 1;

    typedef logic [NCLS-1:0] pend_t;
    typedef logic [NEN-1:0]  en_t;

    // Per-enable-group hit: pending error of that group with its enable set.
    function automatic en_t group_hits(input pend_t p, input en_t e);
        en_t h;
        h[GRP_UE] = p[IDX_UE] & e[GRP_UE];
        h[GRP_CD] = (p[IDX_CE] | p[IDX_DG]) & e[GRP_CD];
        return h;
    endfunction
endpackage

// File: rtl/rerr_status_reg.sv
// Sticky pending-error bits with write-one-to-clear.
// Assumes det and clr are single-cycle qualified vectors; set wins over clear.
module rerr_status_reg
    import rerr_pkg::*;
#(
    parameter int W = NCLS
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] det,
    input  logic [W-1:0] clr,
    output logic [W-1:0] pend
);
    generate
        for (genvar i = 0; i < W; i++) begin : g_bit
            // Hold, clear on write-one, set on detection (detection has priority).
            always_ff @(posedge clk) begin
                if (!rst_n)      pend[i] <= 1'b0;
                else if (det[i]) pend[i] <= 1'b1;
                else if (clr[i]) pend[i] <= 1'b0;
            end

            assert_det_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
                det[i] |=> pend[i]);
            assert_set_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
                (det[i] && clr[i]) |=> pend[i]);
            assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
                (clr[i] && !det[i]) |=> !pend[i]);
            assert_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
                (!clr[i] && !det[i]) |=> $stable(pend[i]));
        end
    endgenerate
endmodule

// File: rtl/rerr_enable_reg.sv
// Trap enable register, plain store on write.
// Assumes wr is already address-qualified by the top.
module rerr_enable_reg
    import rerr_pkg::*;
#(
    parameter int W = NEN
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] en
);
    // Load new enables on a qualified write.
    always_ff @(posedge clk) begin
        if (!rst_n)  en <= '0;
        else if (wr) en <= wdata;
    end

    assert_en_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> $stable(en));
    assert_en_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> (en == $past(wdata)));
endmodule

// File: rtl/rerr_trap_latch.sv
// Latches the error-trap request one cycle after any group hit and holds it,
// with the arming cause, until acknowledged. Acknowledge has priority, so a
// still-true condition re-arms one cycle later. The latch deliberately does
// not re-check live status while held.
module rerr_trap_latch
    import rerr_pkg::*;
#(
    parameter int W = NEN
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] hits,
    input  logic         ack,
    output logic         req,
    output logic [W-1:0] cause
);
    logic fire;
    logic arm;

    // Any enabled group with a pending error.
    always_comb fire = |hits;
    // A new request is taken only from the idle state.
    always_comb arm  = fire && !req && !ack;

    // Request flag: cleared by acknowledge, set by a hit, otherwise held.
    always_ff @(posedge clk) begin
        if (!rst_n)    req <= 1'b0;
        else if (ack)  req <= 1'b0;
        else if (fire) req <= 1'b1;
    end

    // Cause snapshot taken when the request arms.
    always_ff @(posedge clk) begin
        if (!rst_n)   cause <= '0;
        else if (ack) cause <= '0;
        else if (arm) cause <= hits;
    end

    assert_arm_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !ack) |=> req);
    assert_no_spurious_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!req && !fire) |=> !req);
    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !ack) |=> req);
    assert_ack_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !req);
    assert_cause_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !ack) |=> $stable(cause));
    assert_cause_nonzero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req) |-> (cause != '0));
endmodule

// File: rtl/rerr_ctrl.sv
// Top of the restrainable error controller: register decode, read mux,
// pending status, enables and the trap-request latch.
// Assumes detections are single-cycle pulses from the error checker and the
// register port issues at most one write per cycle; reads are combinational.
module rerr_ctrl
    import rerr_pkg::*;
#(
    parameter int          DW          = 32,
    parameter int          AW          = 4,
    parameter logic [AW-1:0] STATUS_ADDR = AW'(0),
    parameter logic [AW-1:0] ENABLE_ADDR = AW'(1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          det_ue,
    input  logic          det_ce,
    input  logic          det_dg,
    input  logic [AW-1:0] reg_addr,
    input  logic          reg_wen,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    input  logic          trap_ack,
    output logic          trap_req,
    output logic [NEN-1:0] trap_cause
);
    localparam int PAD_ST = DW - NCLS;
    localparam int PAD_EN = DW - NEN;

    pend_t det_vec;
    pend_t clr_vec;
    pend_t pend;
    en_t   en;
    en_t   hits;
    logic  hit_st;
    logic  hit_en;
    logic  unused_wbits;

    // Address match for each mapped register.
    always_comb begin
        hit_st = (reg_addr == STATUS_ADDR);
        hit_en = (reg_addr == ENABLE_ADDR);
    end

    // Gather detection pulses in status bit order.
    always_comb begin
        det_vec         = '0;
        det_vec[IDX_UE] = det_ue;
        det_vec[IDX_CE] = det_ce;
        det_vec[IDX_DG] = det_dg;
    end

    // Write-one-to-clear mask, only on a status write.
    always_comb clr_vec = (reg_wen && hit_st) ? reg_wdata[NCLS-1:0] : '0;

    // Upper write-data bits are not backed by storage.
    always_comb unused_wbits = ^reg_wdata[DW-1:NCLS];

    rerr_status_reg #(.W(NCLS)) u_status (
        .clk  (clk),
        .rst_n(rst_n),
        .det  (det_vec),
        .clr  (clr_vec),
        .pend (pend)
    );

    rerr_enable_reg #(.W(NEN)) u_enable (
        .clk  (clk),
        .rst_n(rst_n),
        .wr   (reg_wen && hit_en),
        .wdata(reg_wdata[NEN-1:0]),
        .en   (en)
    );

    // Group hits feeding the trap latch.
    always_comb hits = group_hits(pend, en);

    rerr_trap_latch #(.W(NEN)) u_trap (
        .clk  (clk),
        .rst_n(rst_n),
        .hits (hits),
        .ack  (trap_ack),
        .req  (trap_req),
        .cause(trap_cause)
    );

    // Read mux, zero for unmapped addresses.
    always_comb begin
        if (hit_st)      reg_rdata = {{PAD_ST{1'b0}}, pend};
        else if (hit_en) reg_rdata = {{PAD_EN{1'b0}}, en};
        else             reg_rdata = '0;
    end

    assert_reset_R1: assert property (@(posedge clk)
        !rst_n |=> (pend == '0 && en == '0 && !trap_req && trap_cause == '0));
    assert_unmapped_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wen && !hit_st && !hit_en) |=> ($stable(pend) || $past(|det_vec)) && $stable(en));
endmodule

// File: tb/tb_rerr_ctrl.sv
// Scoreboard bench: the driver keeps a requirement-level model, pushes the
// expected outputs for each cycle into a queue, and the monitor compares them
// at mid-cycle.
module tb_rerr_ctrl;
    localparam int DW = 32;
    localparam int AW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          det_ue = 0, det_ce = 0, det_dg = 0;
    logic [AW-1:0] reg_addr = '0;
    logic          reg_wen = 0;
    logic [DW-1:0] reg_wdata = '0;
    logic [DW-1:0] reg_rdata;
    logic          trap_ack = 0;
    logic          trap_req;
    logic [1:0]    trap_cause;

    rerr_ctrl #(.DW(DW), .AW(AW)) dut (
        .clk(clk), .rst_n(rst_n), .det_ue(det_ue), .det_ce(det_ce), .det_dg(det_dg),
        .reg_addr(reg_addr), .reg_wen(reg_wen), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .trap_ack(trap_ack), .trap_req(trap_req),
        .trap_cause(trap_cause)
    );

    always #10 clk = ~clk;   // 50 MHz

    typedef struct { int sel; logic [DW-1:0] exp; string tag; } item_t;
    item_t sb[$];
    int checks = 0;
    int errors = 0;
    bit done = 0;
    string cur_tag = "R1";

    // Model of the requirements.
    logic [2:0] m_st = '0;
    logic [1:0] m_en = '0, m_cause = '0;
    logic       m_req = 0;

    // Monitor: compare every queued expectation at mid-cycle.
    always @(negedge clk) begin
        while (sb.size() > 0) begin
            item_t it;
            logic [DW-1:0] act;
            it = sb.pop_front();
            act = (it.sel == 0) ? reg_rdata : (it.sel == 1) ? DW'(trap_req) : DW'(trap_cause);
            checks++;
            if (act !== it.exp) begin
                errors++;
                $display("FAIL %s sel=%0d actual=%h expected=%h", it.tag, it.sel, act, it.exp);
            end
        end
    end

    // One clock: advance model from current inputs, clear pulses, queue trap checks.
    task automatic tick();
        logic [2:0] st_n;
        logic [1:0] h;
        h[0] = m_st[0] & m_en[0];
        h[1] = (m_st[1] | m_st[2]) & m_en[1];
        st_n = m_st;
        if (reg_wen && reg_addr == 0) st_n = st_n & ~reg_wdata[2:0];
        st_n = st_n | {det_dg, det_ce, det_ue};
        if (!rst_n) begin
            m_st = '0; m_en = '0; m_req = 0; m_cause = '0;
        end else begin
            if (trap_ack) begin m_req = 0; m_cause = '0; end
            else if (h != 0) begin
                if (!m_req) m_cause = h;
                m_req = 1;
            end
            if (reg_wen && reg_addr == 1) m_en = reg_wdata[1:0];
            m_st = st_n;
        end
        @(posedge clk); #1;
        det_ue = 0; det_ce = 0; det_dg = 0; reg_wen = 0; trap_ack = 0;
        sb.push_back('{1, DW'(m_req), cur_tag});
        sb.push_back('{2, DW'(m_cause), cur_tag});
    endtask

    // Queue a read check of one address in the current cycle.
    task automatic rd(input logic [AW-1:0] a, input string tag);
        logic [DW-1:0] e;
        reg_addr = a;
        e = (a == 0) ? DW'(m_st) : (a == 1) ? DW'(m_en) : '0;
        sb.push_back('{0, e, tag});
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        reg_addr = a; reg_wen = 1; reg_wdata = d;
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #1;
        tick(); tick();
        rst_n = 1;
        tick();
        cur_tag = "R1"; rd(0, "R1"); tick(); rd(1, "R1"); tick();

        // R2 + R6: detect with enables off, no trap.
        cur_tag = "R6";
        det_ue = 1; tick(); rd(0, "R2"); tick(); tick(); rd(0, "R2");
        det_dg = 1; tick(); rd(0, "R2"); tick();
        // R3: write zero keeps, write one clears.
        wr(0, 32'h0); tick(); rd(0, "R3"); tick();
        wr(0, 32'h1); tick(); rd(0, "R3"); tick();
        // R4: detection collides with clear on bit 2.
        det_dg = 1; wr(0, 32'hFFFF_FFFF); tick(); rd(0, "R4"); tick();
        wr(0, 32'h7); tick(); rd(0, "R4"); tick();
        // R10: unmapped write/read.
        wr(4'h5, 32'hFFFF_FFFF); tick(); rd(4'h5, "R10"); tick(); rd(1, "R10"); tick(); rd(0, "R10"); tick();
        // R5: enable store, upper bits masked.
        wr(1, 32'hFFFF_FFFE); tick(); rd(1, "R5"); tick();
        wr(1, 32'h0); tick(); rd(1, "R5"); tick();

        // R6/R7 race: CE with group enable, clear status while request held.
        cur_tag = "R6";
        wr(1, 32'h2); tick();
        det_ce = 1; tick(); tick();
        cur_tag = "R7";
        wr(0, 32'h2); tick(); rd(0, "R7"); tick(); tick();
        trap_ack = 1; tick(); tick();

        // R8 + R9: UE-caused trap, clear CE-class state, re-arm after ack.
        cur_tag = "R9";
        wr(1, 32'h3); tick();
        det_ue = 1; det_dg = 1; tick(); tick();
        wr(0, 32'h4); tick(); tick();
        cur_tag = "R8";
        trap_ack = 1; tick(); tick(); tick();
        cur_tag = "R9";
        wr(0, 32'h1); tick(); tick();
        trap_ack = 1; tick(); tick();
        cur_tag = "R7";
        det_ce = 1; tick(); tick(); wr(1, 32'h0); tick(); tick();
        trap_ack = 1; tick(); tick(); tick();
        rd(0, "R2"); tick();

        tick();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule